// File: doc/BRIEF.md
# Mirrored Thread-Context Status Register Bank

This block is the register bank behind the status controls of a multithreaded processor core. It holds a single shared processor status word, a single address-space word whose low byte is the active address-space identifier, a small target register that names a thread context for cross-thread accesses, and one thread-context status word for each hardware thread context. The coprocessor-usable bits, the extended-mode flag, the privilege field and the address-space identifier are each kept in more than one register. Every write path keeps all copies in step, so a read of any view in the next cycle already shows the new value.

Accesses select a register and a thread context. The context is either the locally running one or, when the cross-thread input is set, the one named by the target register. The mirroring rules are the same for both. A configuration input enables multithreaded mirroring. Without it, writes to the shared status and address-space words stay out of the per-context words. A pulse tells the surrounding logic that the address-space identifier has changed.

Top module: `tc_status_mirror`

## Requirements
- R1: After reset every register reads zero and `asid_chg` is low.
- R2: `sel` encodes 0 = shared status, 1 = address-space word, 2 = thread-context status of the selected context, 3 = target register. `rd_data` shows the selected register with no merging, and a write with `wr_en` high stores `wr_data` into it at the clock edge, so a read in the next cycle returns the new word (the target register keeps only bits 7:0 and reads them zero-extended).
- R3: A shared-status write with `mt_en` high also rewrites the selected context's status word. Context bits 31:28 take status bits 31:28, context bit 27 takes status bit 24, context bits 12:11 take status bits 4:3, and context bits 7:0 take the address-space word's bits 7:0. All other bits and all other contexts are unchanged.
- R4: A shared-status write with `mt_en` low leaves every thread-context status word unchanged.
- R5: A thread-context status write, whatever `mt_en` is, stores the whole word in the selected context. It copies context bits 31:28, 27 and 12:11 into status bits 31:28, 24 and 4:3, with the other status bits unchanged. It also copies context bits 7:0 into address-space bits 7:0, with address-space bits 31:8 unchanged.
- R6: An address-space write with `mt_en` high also replaces bits 7:0 of the selected context's status word, leaving its other bits unchanged. With `mt_en` low no context word changes.
- R7: The selected context is `cur_tc` when `xtc` is low, and the low log2(NUM_TC) bits of the target register when `xtc` is high.
- R8: `asid_chg` is high for the one cycle after a write (address-space or thread-context status) that changes address-space bits 7:0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Multithreaded mirroring enable |
| sel | input | 2 | Register select |
| xtc | input | 1 | Use target register instead of cur_tc |
| cur_tc | input | log2(NUM_TC) | Locally running thread context |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| asid_chg | output | 1 | Address-space identifier changed pulse |

## Verification
A lost mirror update shows at the ports only when the other view is read. For that reason every write is followed at once by a read of all views: the shared status, the address-space word, the target register and every thread-context word. A stale copy is then caught in the cycle after the faulty write. A wrong context decode shows up as a change to a context that should have kept its value. A mis-timed or missing `asid_chg` is seen directly in the cycle right after the write edge. Writes that repeat the current identifier check that no spurious pulse appears.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   localparam int DW = 32;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_ADDRSP = 2'd1,
      SEL_TCSTAT = 2'd2,
      SEL_TARGET = 2'd3
   } tcm_sel_e;

   // field positions inside the shared status word
   localparam int ST_CU_LO  = 28;
   localparam int ST_MX     = 24;
   localparam int ST_KSU_LO = 3;
   // field positions inside a thread-context status word
   localparam int TC_CU_LO  = 28;
   localparam int TC_MX     = 27;
   localparam int TC_KSU_LO = 11;

   typedef struct packed {
      logic [3:0] cu;
      logic       mx;
      logic [1:0] ksu;
   } tcm_mirror_t;

   function automatic tcm_mirror_t mir_from_status(input logic [DW-1:0] v);
      tcm_mirror_t m;
      m.cu  = v[ST_CU_LO +: 4];
      m.mx  = v[ST_MX];
      m.ksu = v[ST_KSU_LO +: 2];
      return m;
   endfunction

   function automatic tcm_mirror_t mir_from_tc(input logic [DW-1:0] v);
      tcm_mirror_t m;
      m.cu  = v[TC_CU_LO +: 4];
      m.mx  = v[TC_MX];
      m.ksu = v[TC_KSU_LO +: 2];
      return m;
   endfunction

   function automatic logic [DW-1:0] mir_into_status(input logic [DW-1:0] old,
                                                     input tcm_mirror_t m);
      logic [DW-1:0] r;
      r = old;
      r[ST_CU_LO +: 4]  = m.cu;
      r[ST_MX]          = m.mx;
      r[ST_KSU_LO +: 2] = m.ksu;
      return r;
   endfunction

   function automatic logic [DW-1:0] mir_into_tc(input logic [DW-1:0] old,
                                                 input tcm_mirror_t m);
      logic [DW-1:0] r;
      r = old;
      r[TC_CU_LO +: 4]  = m.cu;
      r[TC_MX]          = m.mx;
      r[TC_KSU_LO +: 2] = m.ksu;
      return r;
   endfunction
endpackage

// File: rtl/tcm_wr_decode.sv
module tcm_wr_decode
   import tcm_pkg::*;
#(
   parameter int NUM_TC = 4,
   parameter int TGT_W  = 8,
   localparam int TC_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
   input  logic             wr_en,
   input  tcm_sel_e         sel,
   input  logic             xtc,
   input  logic [TC_W-1:0]  cur_tc,
   input  logic [TGT_W-1:0] target,
   input  logic             mt_en,
   output logic [TC_W-1:0]  ctx_idx,
   output logic             we_status,
   output logic             we_addrsp,
   output logic             we_tcstat,
   output logic             we_target,
   output logic             sync_st2tc,
   output logic             sync_as2tc
);
   always_comb begin
      ctx_idx    = xtc ? target[TC_W-1:0] : cur_tc;
      we_status  = wr_en && (sel == SEL_STATUS);
      we_addrsp  = wr_en && (sel == SEL_ADDRSP);
      we_tcstat  = wr_en && (sel == SEL_TCSTAT);
      we_target  = wr_en && (sel == SEL_TARGET);
      sync_st2tc = we_status && mt_en;
      sync_as2tc = we_addrsp && mt_en;
   end
endmodule

// File: rtl/tcm_tc_bank.sv
module tcm_tc_bank
   import tcm_pkg::*;
#(
   parameter int NUM_TC = 4,
   parameter int ASID_W = 8,
   localparam int TC_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TC_W-1:0]   ctx_idx,
   input  logic              we_full,
   input  logic              sync_st,
   input  logic              sync_as,
   input  logic [DW-1:0]     wr_data,
   input  logic [ASID_W-1:0] cur_asid,
   output logic [DW-1:0]     tc_q [NUM_TC]
);
   for (genvar g = 0; g < NUM_TC; g++) begin : g_ctx
      logic          hit;
      logic [DW-1:0] nxt;

      always_comb begin
         hit = (ctx_idx == TC_W'(g));
         nxt = tc_q[g];
         if (hit && we_full) begin
            nxt = wr_data;
         end else if (hit && sync_st) begin
            nxt = mir_into_tc(tc_q[g], mir_from_status(wr_data));
            nxt[ASID_W-1:0] = cur_asid;
         end else if (hit && sync_as) begin
            nxt[ASID_W-1:0] = wr_data[ASID_W-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) tc_q[g] <= '0;
         else        tc_q[g] <= nxt;
      end
   end
endmodule

// File: rtl/tcm_shared.sv
module tcm_shared
   import tcm_pkg::*;
#(
   parameter int ASID_W = 8,
   parameter int TGT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_status,
   input  logic             we_addrsp,
   input  logic             we_tcstat,
   input  logic             we_target,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    status_q,
   output logic [DW-1:0]    addrsp_q,
   output logic [TGT_W-1:0] target_q,
   output logic             asid_chg
);
   logic [DW-1:0] status_d;
   logic [DW-1:0] addrsp_d;

   always_comb begin
      status_d = status_q;
      if (we_status)      status_d = wr_data;
      else if (we_tcstat) status_d = mir_into_status(status_q, mir_from_tc(wr_data));

      addrsp_d = addrsp_q;
      if (we_addrsp)      addrsp_d = wr_data;
      else if (we_tcstat) addrsp_d[ASID_W-1:0] = wr_data[ASID_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         addrsp_q <= '0;
         target_q <= '0;
         asid_chg <= 1'b0;
      end else begin
         status_q <= status_d;
         addrsp_q <= addrsp_d;
         if (we_target) target_q <= wr_data[TGT_W-1:0];
         asid_chg <= (addrsp_d[ASID_W-1:0] != addrsp_q[ASID_W-1:0]);
      end
   end
endmodule

// File: rtl/tc_status_mirror.sv
module tc_status_mirror
   import tcm_pkg::*;
#(
   parameter int NUM_TC = 4,
   parameter int ASID_W = 8,
   parameter int TGT_W  = 8,
   localparam int TC_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mt_en,
   input  logic [1:0]      sel,
   input  logic            xtc,
   input  logic [TC_W-1:0] cur_tc,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   output logic [DW-1:0]   rd_data,
   output logic            asid_chg
);
   initial begin
      if (NUM_TC < 2 || NUM_TC > 256 || (NUM_TC & (NUM_TC - 1)) != 0)
         $error("NUM_TC must be a power of two from 2 to 256");
      if (ASID_W < 1 || ASID_W > TC_KSU_LO)
         $error("ASID_W must fit below the privilege field");
      if (TGT_W < TC_W || TGT_W > DW)
         $error("TGT_W must cover the context index");
   end

   tcm_sel_e         sel_e;
   logic [TC_W-1:0]  ctx_idx;
   logic             we_status, we_addrsp, we_tcstat, we_target;
   logic             sync_st2tc, sync_as2tc;
   logic [DW-1:0]    status_q, addrsp_q;
   logic [TGT_W-1:0] target_q;
   logic [DW-1:0]    tc_q [NUM_TC];

   assign sel_e = tcm_sel_e'(sel);

   tcm_wr_decode #(.NUM_TC(NUM_TC), .TGT_W(TGT_W)) u_dec (
      .wr_en      (wr_en),
      .sel        (sel_e),
      .xtc        (xtc),
      .cur_tc     (cur_tc),
      .target     (target_q),
      .mt_en      (mt_en),
      .ctx_idx    (ctx_idx),
      .we_status  (we_status),
      .we_addrsp  (we_addrsp),
      .we_tcstat  (we_tcstat),
      .we_target  (we_target),
      .sync_st2tc (sync_st2tc),
      .sync_as2tc (sync_as2tc)
   );

   tcm_shared #(.ASID_W(ASID_W), .TGT_W(TGT_W)) u_shr (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_status (we_status),
      .we_addrsp (we_addrsp),
      .we_tcstat (we_tcstat),
      .we_target (we_target),
      .wr_data   (wr_data),
      .status_q  (status_q),
      .addrsp_q  (addrsp_q),
      .target_q  (target_q),
      .asid_chg  (asid_chg)
   );

   tcm_tc_bank #(.NUM_TC(NUM_TC), .ASID_W(ASID_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctx_idx  (ctx_idx),
      .we_full  (we_tcstat),
      .sync_st  (sync_st2tc),
      .sync_as  (sync_as2tc),
      .wr_data  (wr_data),
      .cur_asid (addrsp_q[ASID_W-1:0]),
      .tc_q     (tc_q)
   );

   always_comb begin
      unique case (sel_e)
         SEL_STATUS: rd_data = status_q;
         SEL_ADDRSP: rd_data = addrsp_q;
         SEL_TCSTAT: rd_data = tc_q[ctx_idx];
         default:    rd_data = DW'(target_q);
      endcase
   end
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker
   import tcm_pkg::*;
#(
   parameter int NUM_TC = 4,
   parameter int ASID_W = 8,
   parameter int TGT_W  = 8,
   localparam int TC_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mt_en,
   input logic [1:0]       sel,
   input logic             xtc,
   input logic [TC_W-1:0]  cur_tc,
   input logic             wr_en,
   input logic [DW-1:0]    wr_data,
   input logic             asid_chg,
   input logic [DW-1:0]    status_q,
   input logic [DW-1:0]    addrsp_q,
   input logic [TGT_W-1:0] target_q,
   input logic [DW-1:0]    tc_q [NUM_TC]
);
   logic [TC_W-1:0] idx;
   logic            p_we, p_mt;
   logic [1:0]      p_sel;
   logic [TC_W-1:0] p_idx;
   logic [DW-1:0]   p_wd, p_addrsp, p_tcsel;

   assign idx = xtc ? target_q[TC_W-1:0] : cur_tc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_we <= 1'b0; p_mt <= 1'b0; p_sel <= '0; p_idx <= '0;
         p_wd <= '0; p_addrsp <= '0; p_tcsel <= '0;
      end else begin
         p_we <= wr_en; p_mt <= mt_en; p_sel <= sel; p_idx <= idx;
         p_wd <= wr_data; p_addrsp <= addrsp_q; p_tcsel <= tc_q[idx];
      end
   end

   AST_STATUS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && p_sel == 2'd0) |-> status_q == p_wd); // R2

   AST_STATUS_TO_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && p_sel == 2'd0 && p_mt) |->
         (tc_q[p_idx][31:28] == p_wd[31:28] && tc_q[p_idx][27] == p_wd[24] &&
          tc_q[p_idx][12:11] == p_wd[4:3] &&
          tc_q[p_idx][ASID_W-1:0] == p_addrsp[ASID_W-1:0])); // R3

   AST_STATUS_NO_MT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && p_sel == 2'd0 && !p_mt) |-> tc_q[p_idx] == p_tcsel); // R4

   AST_TC_TO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && p_sel == 2'd2) |->
         (status_q[31:28] == p_wd[31:28] && status_q[24] == p_wd[27] &&
          status_q[4:3] == p_wd[12:11] &&
          addrsp_q[ASID_W-1:0] == p_wd[ASID_W-1:0] &&
          addrsp_q[DW-1:ASID_W] == p_addrsp[DW-1:ASID_W])); // R5

   AST_ADDRSP_TO_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && p_sel == 2'd1 && p_mt) |->
         (tc_q[p_idx][ASID_W-1:0] == p_wd[ASID_W-1:0] &&
          tc_q[p_idx][DW-1:ASID_W] == p_tcsel[DW-1:ASID_W])); // R6

   AST_ASID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      asid_chg == (addrsp_q[ASID_W-1:0] != p_addrsp[ASID_W-1:0])); // R8
endmodule

bind tc_status_mirror tcm_checker #(.NUM_TC(NUM_TC), .ASID_W(ASID_W), .TGT_W(TGT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mt_en    (mt_en),
   .sel      (sel),
   .xtc      (xtc),
   .cur_tc   (cur_tc),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .asid_chg (asid_chg),
   .status_q (status_q),
   .addrsp_q (addrsp_q),
   .target_q (target_q),
   .tc_q     (tc_q)
);

// File: tb/tb_tc_status_mirror.sv
module tb_tc_status_mirror;
   localparam int PERIOD = 10;
   localparam int NTC    = 4;
   localparam int TCW    = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           mt_en = 1'b0;
   logic [1:0]     sel = '0;
   logic           xtc = 1'b0;
   logic [TCW-1:0] cur_tc = '0;
   logic           wr_en = 1'b0;
   logic [31:0]    wr_data = '0;
   logic [31:0]    rd_data;
   logic           asid_chg;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] m_st, m_as, m_tc [NTC];
   logic [7:0]  m_tg;

   always #(PERIOD/2) clk = ~clk;

   tc_status_mirror #(.NUM_TC(NTC)) dut (
      .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .sel(sel), .xtc(xtc),
      .cur_tc(cur_tc), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .asid_chg(asid_chg)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] tc_from_status(input logic [31:0] old,
                                                  input logic [31:0] s,
                                                  input logic [7:0] id);
      logic [31:0] r = old;
      r[31:28] = s[31:28]; r[27] = s[24]; r[12:11] = s[4:3]; r[7:0] = id;
      return r;
   endfunction

   function automatic logic [31:0] status_from_tc(input logic [31:0] old,
                                                  input logic [31:0] t);
      logic [31:0] r = old;
      r[31:28] = t[31:28]; r[24] = t[27]; r[4:3] = t[12:11];
      return r;
   endfunction

   // write one register, update the model, check the pulse right after the edge
   task automatic wr(input logic [1:0] s, input logic x, input logic [TCW-1:0] c,
                     input logic m, input logic [31:0] d);
      logic [TCW-1:0] idx = x ? m_tg[TCW-1:0] : c;
      logic [7:0]     old_id = m_as[7:0];
      @(negedge clk);
      sel = s; xtc = x; cur_tc = c; mt_en = m; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      case (s)
         2'd0: begin
            m_st = d;                                                  // R2
            if (m) m_tc[idx] = tc_from_status(m_tc[idx], d, m_as[7:0]); // R3, R4
         end
         2'd1: begin
            m_as = d;
            if (m) m_tc[idx][7:0] = d[7:0];                            // R6
         end
         2'd2: begin
            m_tc[idx] = d;                                             // R5
            m_st = status_from_tc(m_st, d);
            m_as[7:0] = d[7:0];
         end
         default: m_tg = d[7:0];                                       // R7
      endcase
      chk("R8 asid_chg", {31'b0, asid_chg}, {31'b0, (m_as[7:0] != old_id)});
   endtask

   task automatic verify_all(input string req);
      wr_en = 1'b0;
      xtc = 1'b0;
      sel = 2'd0; #1 chk({req, " status"}, rd_data, m_st);
      sel = 2'd1; #1 chk({req, " addrsp"}, rd_data, m_as);
      sel = 2'd3; #1 chk({req, " target"}, rd_data, {24'b0, m_tg});
      for (int i = 0; i < NTC; i++) begin
         sel = 2'd2; cur_tc = TCW'(i);
         #1 chk({req, " tcstat"}, rd_data, m_tc[i]);
      end
      sel = 2'd2; xtc = 1'b1;
      #1 chk({req, " R7 xtc read"}, rd_data, m_tc[m_tg[TCW-1:0]]);
      xtc = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_st = '0; m_as = '0; m_tg = '0;
      for (int i = 0; i < NTC; i++) m_tc[i] = '0;
      void'($urandom(32'h1357_9bdf));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 asid_chg reset", {31'b0, asid_chg}, 32'b0);
      verify_all("R1 reset");

      // R3: status write with mirroring, ID from the address-space word
      wr(2'd1, 1'b0, 2'd1, 1'b0, 32'hABCD_0042);   verify_all("R6 addrsp no mt");
      wr(2'd0, 1'b0, 2'd1, 1'b1, 32'hF100_0018);   verify_all("R3 status mt");
      chk("R3 tc1 value", m_tc[1], 32'hF800_1842);
      // R4: status write without mirroring
      wr(2'd0, 1'b0, 2'd2, 1'b0, 32'h5555_5555);   verify_all("R4 status no mt");
      // R5: tc write copies fields and ID, keeps address-space upper bits
      wr(2'd2, 1'b0, 2'd0, 1'b0, 32'h8800_0877);   verify_all("R5 tc write");
      chk("R5 addrsp upper", m_as, 32'hABCD_0077);
      // R8: rewrite of same ID gives no pulse
      wr(2'd1, 1'b0, 2'd0, 1'b1, 32'h0000_0077);   verify_all("R8 same id");
      // R7: cross-thread target 3 from a wide write
      wr(2'd3, 1'b0, 2'd0, 1'b0, 32'hFFFF_FF07);   verify_all("R7 target");
      wr(2'd2, 1'b1, 2'd0, 1'b1, 32'h1234_5678);   verify_all("R7 xtc tc write");
      wr(2'd1, 1'b1, 2'd1, 1'b1, 32'h0000_00FF);   verify_all("R6 xtc addrsp");

      for (int n = 0; n < 500; n++) begin
         logic [31:0] d = $urandom;
         logic [1:0]  s = 2'($urandom % 4);
         if ($urandom % 4 == 0) d[7:0] = m_as[7:0];
         wr(s, 1'($urandom), TCW'($urandom), 1'($urandom), d);
         verify_all("R2 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule